// File: doc/BRIEF.md
# FFT Output Reorder and Formatter

This block sits behind a transform pipeline. The pipeline delivers the complex results of one block in bit-reversed index order. The block stores each block of results in one half of a two-bank buffer. While the reader streams the previous block out of the other half, the next block is written. When a block starts reading, a configuration is captured for it. That configuration picks the first bin, either 0 or half the block length with wraparound. It also picks whether the index is bit-reversed to give natural bin order, which output resolution is used, and whether real and imaginary parts share one bus or travel on two buses.

Every output sample occupies two clocks. In shared-bus mode the real part comes first and the imaginary part second, both on the primary bus. In two-bus mode the imaginary part is on the primary bus and the real part on the secondary bus, and both are held for the two clocks. A one-clock sync pulse marks the first clock of each block. An output-enable flag stands in for the high-impedance state and is low whenever nothing is being sent.

Top module: `fft_out_reorder`

## Requirements
- R1: `out_sync` is high for exactly one clock, the first clock of a block's output. `out_en` stays high for all 2·N clocks of that block, where N = 2^IDX_W.
- R2: With `cfg_offset` = 0, output sample i (i = 0..N-1) carries bin i.
- R3: With `cfg_offset` = 1, output sample i carries bin (i + N/2) mod N. Output therefore starts at bin N/2, climbs to N-1, wraps to 0 and ends at N/2-1.
- R4: Bin b is mapped to a write position. With `cfg_bitrev` = 1 the position is the IDX_W-bit reversal of b, where bit k moves to bit IDX_W-1-k. With `cfg_bitrev` = 0 the position is b itself. The write position is the count of samples accepted into the block before that sample.
- R5: Resolution code `cfg_res` = 00 outputs the low DATA_W-2 bits of the stored value with the top two bits forced to 0. Code 01 outputs the low DATA_W-1 bits with the top bit forced to 0. Codes 10 and 11 output all DATA_W bits.
- R6: In shared-bus mode (`cfg_parallel` = 0), the primary bus carries the real part on the first clock of a sample and the imaginary part on the second. `out_sec` is 0.
- R7: In two-bus mode (`cfg_parallel` = 1), `out_sec` carries the real part and `out_pri` carries the imaginary part. Both are held for both clocks of the sample.
- R8: Holding `rst` high on a clock edge aborts any readout in progress and discards a partly written block. After that edge `out_en`, `out_sync`, `out_pri` and `out_sec` are 0 until a new complete block is written.
- R9: While no block is being output, `out_en`, `out_sync`, `out_pri` and `out_sec` are 0.
- R10: A block can be written while the previous block is being read. If it is complete before the reader's last clock, its sync pulse follows the previous block's last output clock with no gap.
- R11: A sample presented while the write bank holds a complete block not yet handed to the reader is discarded.
- R12: The four configuration inputs are sampled when a block starts reading. A change during readout affects only later blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A result sample is present |
| in_re | input | DATA_W | Real part of the incoming result |
| in_im | input | DATA_W | Imaginary part of the incoming result |
| cfg_offset | input | 1 | Start readout at the half-block bin |
| cfg_bitrev | input | 1 | Apply index bit reversal on readout |
| cfg_res | input | 2 | Output resolution code |
| cfg_parallel | input | 1 | Two-bus output mode |
| out_pri | output | DATA_W | Primary output bus |
| out_sec | output | DATA_W | Secondary output bus (real part in two-bus mode) |
| out_en | output | 1 | Outputs are driven (low models high impedance) |
| out_sync | output | 1 | First clock of a block's output |

## Verification
The hardest state to reach from the ports has three things happening at once. A second block fills while the first is still streaming. Further samples arrive against the full bank. The configuration changes under the running readout. The bench reaches this by forking a writer and a checker. The writer changes every configuration input, writes a new block and then pushes junk samples, while the checker verifies that the first block finishes in its old format and that the second block's sync lands on the very next clock with uncorrupted data. Apart from that, the bench sweeps all 32 configuration combinations on a 16-entry block and computes every expected word from the bin mapping and the resolution rules.

// File: rtl/fft_reorder_pkg.sv
package fft_reorder_pkg;

    // Output resolution selection
    typedef enum logic [1:0] {
        RES_NARROW = 2'b00,
        RES_MID    = 2'b01,
        RES_WIDE   = 2'b10,
        RES_WIDE_X = 2'b11
    } res_e;

    // Per-block readout configuration, captured at block start
    typedef struct packed {
        logic offset;
        logic bitrev;
        res_e res;
        logic parallel;
    } rd_cfg_t;

    // Tag that travels with a memory read toward the formatter
    typedef struct packed {
        logic valid;
        logic ph;
        logic first;
        res_e res;
        logic parallel;
    } rd_tag_t;

    // Number of top bits forced to zero for a resolution code
    function automatic int unsigned res_drop(input res_e r);
        case (r)
            RES_NARROW: res_drop = 2;
            RES_MID:    res_drop = 1;
            default:    res_drop = 0;
        endcase
    endfunction

endpackage

// File: rtl/reorder_wr_ctrl.sv
module reorder_wr_ctrl #(
    parameter int unsigned IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             swap,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_addr,
    output logic             wr_full
);
    localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

    assign wr_en = in_valid && !wr_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_addr <= '0;
            wr_full <= 1'b0;
        end else if (swap) begin
            wr_full <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == LAST) begin
                wr_addr <= '0;
                wr_full <= 1'b1;
            end else begin
                wr_addr <= wr_addr + 1'b1;
            end
        end
    end

    // R11: a full bank ignores further samples until handed over
    p_full_holds_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_full && !swap) |=> (wr_full && wr_addr == '0));

endmodule

// File: rtl/reorder_rd_seq.sv
module reorder_rd_seq
    import fft_reorder_pkg::*;
#(
    parameter int unsigned IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  rd_cfg_t          cfg_in,
    output logic             busy,
    output logic             last,
    output logic             rd_en,
    output logic             first,
    output logic             ph,
    output logic [IDX_W-1:0] rd_addr,
    output rd_cfg_t          cfg_q
);
    localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};
    localparam logic [IDX_W-1:0] HALF = {1'b1, {(IDX_W-1){1'b0}}};

    logic [IDX_W-1:0] cnt;
    logic [IDX_W-1:0] bin;
    logic [IDX_W-1:0] bin_rev;

    assign bin = cnt + (cfg_q.offset ? HALF : '0);

    for (genvar k = 0; k < IDX_W; k++) begin : g_rev
        assign bin_rev[k] = bin[IDX_W-1-k];
    end

    assign rd_addr = cfg_q.bitrev ? bin_rev : bin;
    assign last    = busy && ph && (cnt == LAST);
    assign rd_en   = busy && !ph;
    assign first   = busy && !ph && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            ph    <= 1'b0;
            cnt   <= '0;
            cfg_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            ph    <= 1'b0;
            cnt   <= '0;
            cfg_q <= cfg_in;
        end else if (busy) begin
            ph <= !ph;
            if (ph) begin
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R1: a block start always begins at the first sample, first clock
    p_start_clean_r1: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && !ph && cnt == '0));

    // R2: samples advance one at a time through the block
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && ph && !last && !start) |=> (cnt == $past(cnt) + 1'b1));

    // R12: configuration stays fixed while a block is read
    p_cfg_stable_r12: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> $stable(cfg_q));

endmodule

// File: rtl/reorder_fmt.sv
module reorder_fmt
    import fft_reorder_pkg::*;
#(
    parameter int unsigned DATA_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  rd_tag_t             tag_in,
    input  logic [2*DATA_W-1:0] data_in,
    output logic [DATA_W-1:0]   out_pri,
    output logic [DATA_W-1:0]   out_sec,
    output logic                out_en,
    output logic                out_sync
);
    localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] re_f;
    logic [DATA_W-1:0] im_f;

    assign keep_mask = ONES >> res_drop(tag_in.res);
    assign re_f      = data_in[2*DATA_W-1:DATA_W] & keep_mask;
    assign im_f      = data_in[DATA_W-1:0] & keep_mask;

    always_ff @(posedge clk) begin
        if (rst || !tag_in.valid) begin
            out_pri  <= '0;
            out_sec  <= '0;
            out_en   <= 1'b0;
            out_sync <= 1'b0;
        end else begin
            out_en   <= 1'b1;
            out_sync <= tag_in.first;
            if (tag_in.parallel) begin
                out_pri <= im_f;
                out_sec <= re_f;
            end else begin
                out_pri <= tag_in.ph ? im_f : re_f;
                out_sec <= '0;
            end
        end
    end

    // R1: the sync pulse only appears while outputs are driven
    p_sync_driven_r1: assert property (@(posedge clk) disable iff (rst)
        out_sync |-> out_en);

    // R5: narrow resolution leaves the two top bits clear
    p_narrow_top_r5: assert property (@(posedge clk) disable iff (rst)
        $past(tag_in.valid && tag_in.res == RES_NARROW) |->
            (out_pri[DATA_W-1 -: 2] == 2'b00 && out_sec[DATA_W-1 -: 2] == 2'b00));

    // R6: the secondary bus is quiet in shared-bus mode
    p_shared_sec_r6: assert property (@(posedge clk) disable iff (rst)
        $past(!tag_in.parallel) |-> (out_sec == '0));

    // R9: nothing is driven while disabled
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (out_pri == '0 && out_sec == '0 && !out_sync));

endmodule

// File: rtl/fft_out_reorder.sv
module fft_out_reorder
    import fft_reorder_pkg::*;
#(
    parameter int unsigned IDX_W  = 11,
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_re,
    input  logic [DATA_W-1:0] in_im,
    input  logic              cfg_offset,
    input  logic              cfg_bitrev,
    input  logic [1:0]        cfg_res,
    input  logic              cfg_parallel,
    output logic [DATA_W-1:0] out_pri,
    output logic [DATA_W-1:0] out_sec,
    output logic              out_en,
    output logic              out_sync
);
    localparam int unsigned DEPTH = 2 * (2 ** IDX_W);
    localparam int unsigned WORD  = 2 * DATA_W;

    logic [WORD-1:0]  mem_q [DEPTH];
    logic [WORD-1:0]  rd_q;

    logic             wr_en, wr_full, swap;
    logic [IDX_W-1:0] wr_addr, rd_addr;
    logic             wr_bank, rd_bank;
    logic             rd_busy, rd_last, rd_en, rd_first, rd_ph;
    rd_cfg_t          cfg_live, cfg_q;
    rd_tag_t          tag1;

    assign cfg_live = '{offset: cfg_offset, bitrev: cfg_bitrev,
                        res: res_e'(cfg_res), parallel: cfg_parallel};

    // Hand over only when the write bank is full and the reader is done
    assign swap = wr_full && (!rd_busy || rd_last);

    reorder_wr_ctrl #(.IDX_W(IDX_W)) u_wr (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .swap    (swap),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_full (wr_full)
    );

    reorder_rd_seq #(.IDX_W(IDX_W)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .start  (swap),
        .cfg_in (cfg_live),
        .busy   (rd_busy),
        .last   (rd_last),
        .rd_en  (rd_en),
        .first  (rd_first),
        .ph     (rd_ph),
        .rd_addr(rd_addr),
        .cfg_q  (cfg_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bank <= 1'b0;
            rd_bank <= 1'b1;
        end else if (swap) begin
            rd_bank <= wr_bank;
            wr_bank <= !wr_bank;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[{wr_bank, wr_addr}] <= {in_re, in_im};
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_q <= mem_q[{rd_bank, rd_addr}];
        end
    end

    // Tag stage aligned with the registered memory read
    always_ff @(posedge clk) begin
        if (rst) begin
            tag1 <= '0;
        end else begin
            tag1 <= '{valid: rd_busy, ph: rd_ph, first: rd_first,
                      res: cfg_q.res, parallel: cfg_q.parallel};
        end
    end

    reorder_fmt #(.DATA_W(DATA_W)) u_fmt (
        .clk     (clk),
        .rst     (rst),
        .tag_in  (tag1),
        .data_in (rd_q),
        .out_pri (out_pri),
        .out_sec (out_sec),
        .out_en  (out_en),
        .out_sync(out_sync)
    );

    // R10: reader and writer never share a bank
    p_banks_apart_r10: assert property (@(posedge clk) disable iff (rst)
        rd_busy |-> (rd_bank != wr_bank));

    // R8: a reset edge leaves the outputs undriven
    p_reset_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_en && !out_sync));

endmodule

// File: tb/fft_out_reorder_tb.sv
`timescale 1ns/1ps
module fft_out_reorder_tb;
    localparam int IDX_W  = 4;
    localparam int DATA_W = 12;
    localparam int N      = 2 ** IDX_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_re = '0, in_im = '0;
    logic              cfg_offset = 1'b0, cfg_bitrev = 1'b0, cfg_parallel = 1'b0;
    logic [1:0]        cfg_res = 2'b00;
    logic [DATA_W-1:0] out_pri, out_sec;
    logic              out_en, out_sync;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    fft_out_reorder #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .cfg_offset(cfg_offset), .cfg_bitrev(cfg_bitrev), .cfg_res(cfg_res),
        .cfg_parallel(cfg_parallel), .out_pri(out_pri), .out_sec(out_sec),
        .out_en(out_en), .out_sync(out_sync)
    );

    function automatic logic [DATA_W-1:0] val_re(int blk, int p);
        return DATA_W'((blk * 421 + p * 167 + 2565) % 4096);
    endfunction

    function automatic logic [DATA_W-1:0] val_im(int blk, int p);
        return DATA_W'((blk * 97 + p * 613 + 3015) % 4096);
    endfunction

    function automatic int brev(int b);
        int r = 0;
        for (int k = 0; k < IDX_W; k++) if (b & (1 << k)) r |= 1 << (IDX_W - 1 - k);
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] fit(logic [DATA_W-1:0] v, int res);
        if (res == 0) return DATA_W'(v % 1024);
        if (res == 1) return DATA_W'(v % 2048);
        return v;
    endfunction

    task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_quiet(string tag);
        check({tag, " en"}, DATA_W'(out_en), '0);
        check({tag, " sync"}, DATA_W'(out_sync), '0);
        check({tag, " pri"}, out_pri, '0);
        check({tag, " sec"}, out_sec, '0);
    endtask

    task automatic write_block(int blk);
        for (int p = 0; p < N; p++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_re    = val_re(blk, p);
            in_im    = val_im(blk, p);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_sync();
        int n = 0;
        @(negedge clk);
        while (!out_sync && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Current negedge must be the sync clock of the block
    task automatic check_block(int blk, bit off, bit br, int res, bit par);
        string order_t = off ? "R3" : "R2";
        string res_t   = "R5";
        string bus_t   = par ? "R7" : "R6";
        for (int i = 0; i < N; i++) begin
            int b = (i + (off ? N / 2 : 0)) % N;
            int p = br ? brev(b) : b;        // R4 mapping
            logic [DATA_W-1:0] er = fit(val_re(blk, p), res);
            logic [DATA_W-1:0] ei = fit(val_im(blk, p), res);
            for (int ph = 0; ph < 2; ph++) begin
                string tg = $sformatf("%s R4 %s %s blk%0d s%0d ph%0d",
                                      order_t, res_t, bus_t, blk, i, ph);
                if (i != 0 || ph != 0) @(negedge clk);
                check({"R1 en ", tg}, DATA_W'(out_en), 1);
                check({"R1 sync ", tg}, DATA_W'(out_sync), DATA_W'(i == 0 && ph == 0));
                if (par) begin
                    check({"pri ", tg}, out_pri, ei);
                    check({"sec ", tg}, out_sec, er);
                end else begin
                    check({"pri ", tg}, out_pri, ph == 0 ? er : ei);
                    check({"sec ", tg}, out_sec, '0);
                end
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check_quiet("R8 during reset");
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check_quiet("R9 idle after reset");

        // Sweep every configuration: offset, bit reversal, resolution, bus mode
        for (int c = 0; c < 32; c++) begin
            cfg_offset   = c[0];
            cfg_bitrev   = c[1];
            cfg_res      = 2'(c >> 2);
            cfg_parallel = c[4];
            write_block(c + 1);
            wait_sync();
            check_block(c + 1, c[0], c[1], (c >> 2) & 3, c[4]);
            @(negedge clk);
            check_quiet("R9 idle after block");
        end

        // R10 R11 R12: overlap write, junk against full bank, config change
        cfg_offset = 1'b1; cfg_bitrev = 1'b1; cfg_res = 2'b00; cfg_parallel = 1'b0;
        write_block(50);
        wait_sync();
        fork
            begin
                check_block(50, 1'b1, 1'b1, 0, 1'b0);   // R12 old format holds
                @(negedge clk);                          // R10 no gap
                check_block(51, 1'b0, 1'b0, 2, 1'b1);   // R11 junk dropped
            end
            begin
                @(negedge clk);
                cfg_offset = 1'b0; cfg_bitrev = 1'b0; cfg_res = 2'b10; cfg_parallel = 1'b1;
                write_block(51);
                for (int j = 0; j < 5; j++) begin
                    @(negedge clk);
                    in_valid = 1'b1;
                    in_re = '1;
                    in_im = '1;
                end
                @(negedge clk);
                in_valid = 1'b0;
            end
        join
        @(negedge clk);
        check_quiet("R9 idle after overlap");

        // R8: reset aborts readout and a partial block
        cfg_offset = 1'b0; cfg_bitrev = 1'b1; cfg_res = 2'b01; cfg_parallel = 1'b0;
        write_block(60);
        wait_sync();
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_re = 12'h5A5;
            in_im = 12'hA5A;
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int j = 0; j < 40; j++) begin
            check_quiet("R8 after reset");
            @(negedge clk);
        end
        write_block(61);
        wait_sync();
        check_block(61, 1'b0, 1'b1, 1, 1'b0);

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule